// File: doc/BRIEF.md
# Hardware Cursor Overlay Unit

This block sits in a display pixel pipeline and paints a 32x32 cursor over the stream of palette indices. Each cycle it may receive one pixel: its palette index, its raster X and Y, and a valid flag. One cycle later it returns either the original index, one of two programmable cursor color indices, or the bitwise inverse of the original index. Palette lookup is outside the block.

The cursor shape is held in a small byte store with room for two patterns. Each pattern has two bits per pixel, taken from two planes. For each cursor line, the four plane-0 bytes are followed by the four plane-1 bytes. A two-bit select input chooses pattern 0, pattern 1 or no cursor. The cursor's top-left corner is set by two 11-bit position inputs.

Top module: `cursor_overlay`

## Requirements
- R1: `out_valid_o` equals `pix_valid_i` from the previous clock edge. When `out_valid_o` is low, `out_idx_o` is zero.
- R2: `cur_sel_i` selects the cursor as follows: 2'b01 uses pattern 0, 2'b10 uses pattern 1, and 2'b00 or 2'b11 disables the cursor. While the cursor is disabled, every valid pixel index is returned unchanged.
- R3: The cursor box covers X from `cur_x_i` to `cur_x_i`+31 and Y from `cur_y_i` to `cur_y_i`+31. A Y position of 0 puts the box on the top line. A valid pixel outside the box is returned unchanged.
- R4: Pattern p (0 or 1) occupies store addresses p*256 to p*256+255. For a pixel at box offset (dx,dy), its plane-0 bit is in byte dy*8+dx/8 and its plane-1 bit is in byte dy*8+4+dx/8. Within each byte the bit position is 7-(dx mod 8), so bit 7 is the leftmost pixel.
- R5: Inside the box, plane bits {p1,p0}=00 output `col0_i`.
- R6: Inside the box, plane bits 01 output `col1_i`.
- R7: Inside the box, plane bits 10 are transparent and return the original index.
- R8: Inside the box, plane bits 11 return the ones' complement of the original index.
- R9: After reset, `out_valid_o` and `out_idx_o` are zero.
- R10: The cursor box does not wrap at the top of the 11-bit coordinate range. Pixels with small X or Y never fall inside a box that is placed near coordinate 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pat_we_i | input | 1 | Pattern store write enable |
| pat_waddr_i | input | 9 | Pattern store byte address (bit 8 selects the pattern) |
| pat_wdata_i | input | 8 | Pattern store write data |
| cur_sel_i | input | 2 | Cursor select: 01 pattern 0, 10 pattern 1, others off |
| cur_x_i | input | 11 | Cursor left column |
| cur_y_i | input | 11 | Cursor top line |
| col0_i | input | 8 | Cursor color index 0 |
| col1_i | input | 8 | Cursor color index 1 |
| pix_valid_i | input | 1 | Incoming pixel valid |
| pix_idx_i | input | 8 | Incoming pixel palette index |
| pix_x_i | input | 11 | Incoming pixel column |
| pix_y_i | input | 11 | Incoming pixel line |
| out_valid_o | output | 1 | Outgoing pixel valid |
| out_idx_o | output | 8 | Outgoing palette index |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid delay and the zero index on idle cycles;
- pass-through while the cursor is off;
- pass-through outside a box that the checker computes on its own;
- that a pixel inside the box always leaves as one of the four legal values.

Which of those four values is chosen depends on the stored plane bits and their byte layout, and only the bench's sweeps show that. The sweeps cover every pixel of both patterns and the box near the top of the coordinate range, and compare against a model built from the address formula.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    typedef enum logic [1:0] {
        MODE_COL0  = 2'b00,
        MODE_COL1  = 2'b01,
        MODE_CLEAR = 2'b10,
        MODE_INV   = 2'b11
    } cur_mode_e;

    typedef enum logic [1:0] {
        SEL_OFF   = 2'b00,
        SEL_PAT0  = 2'b01,
        SEL_PAT1  = 2'b10,
        SEL_OFF_B = 2'b11
    } cur_sel_e;
endpackage

// File: rtl/cursor_window.sv
module cursor_window #(
    parameter int COORD_W = 11,
    parameter int CUR_DIM = 32,
    localparam int OFF_W  = $clog2(CUR_DIM)
) (
    input  logic [COORD_W-1:0] pix_x_i,
    input  logic [COORD_W-1:0] pix_y_i,
    input  logic [COORD_W-1:0] cur_x_i,
    input  logic [COORD_W-1:0] cur_y_i,
    output logic               hit_o,
    output logic [OFF_W-1:0]   off_x_o,
    output logic [OFF_W-1:0]   off_y_o
);
    logic [COORD_W:0] dx, dy;
    logic             hit_x, hit_y;

    // A borrow in the wide difference means the pixel lies left of or
    // above the box, so the box cannot wrap around the coordinate range.
    always_comb begin
        dx      = {1'b0, pix_x_i} - {1'b0, cur_x_i};
        dy      = {1'b0, pix_y_i} - {1'b0, cur_y_i};
        hit_x   = (dx < (COORD_W+1)'(CUR_DIM));
        hit_y   = (dy < (COORD_W+1)'(CUR_DIM));
        hit_o   = hit_x && hit_y;
        off_x_o = dx[OFF_W-1:0];
        off_y_o = dy[OFF_W-1:0];
    end
endmodule

// File: rtl/cursor_pat_store.sv
module cursor_pat_store #(
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 512,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr0_i,
    input  logic [AW-1:0]     raddr1_i,
    output logic [BYTE_W-1:0] rdata0_o,
    output logic [BYTE_W-1:0] rdata1_o
);
    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata0_o = mem_q[raddr0_i];
    assign rdata1_o = mem_q[raddr1_i];
endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
    import cursor_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             active_i,
    input  cur_mode_e        mode_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [IDX_W-1:0] col0_i,
    input  logic [IDX_W-1:0] col1_i,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = idx_i;
        if (active_i) begin
            unique case (mode_i)
                MODE_COL0:  idx_o = col0_i;
                MODE_COL1:  idx_o = col1_i;
                MODE_CLEAR: idx_o = idx_i;
                MODE_INV:   idx_o = ~idx_i;
                default:    idx_o = idx_i;
            endcase
        end
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int COORD_W = 11,
    parameter int IDX_W   = 8,
    parameter int CUR_DIM = 32,
    localparam int BYTE_W     = 8,
    localparam int OFF_W      = $clog2(CUR_DIM),
    localparam int COL_W      = OFF_W - $clog2(BYTE_W),
    localparam int PAT_BYTES  = CUR_DIM * CUR_DIM * 2 / BYTE_W,
    localparam int STORE_D    = 2 * PAT_BYTES,
    localparam int STORE_AW   = $clog2(STORE_D)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pat_we_i,
    input  logic [STORE_AW-1:0] pat_waddr_i,
    input  logic [BYTE_W-1:0]   pat_wdata_i,
    input  logic [1:0]          cur_sel_i,
    input  logic [COORD_W-1:0]  cur_x_i,
    input  logic [COORD_W-1:0]  cur_y_i,
    input  logic [IDX_W-1:0]    col0_i,
    input  logic [IDX_W-1:0]    col1_i,
    input  logic                pix_valid_i,
    input  logic [IDX_W-1:0]    pix_idx_i,
    input  logic [COORD_W-1:0]  pix_x_i,
    input  logic [COORD_W-1:0]  pix_y_i,
    output logic                out_valid_o,
    output logic [IDX_W-1:0]    out_idx_o
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } out_s;

    out_s state_d, state_q;

    logic               hit;
    logic [OFF_W-1:0]   off_x, off_y;
    logic               enabled, pat_bit;
    logic [STORE_AW-1:0] addr_p0, addr_p1;
    logic [BYTE_W-1:0]  byte_p0, byte_p1;
    logic [$clog2(BYTE_W)-1:0] bit_sel;
    cur_mode_e          mode;
    logic [IDX_W-1:0]   mixed_idx;

    cursor_window #(.COORD_W(COORD_W), .CUR_DIM(CUR_DIM)) i_window (
        .pix_x_i (pix_x_i),
        .pix_y_i (pix_y_i),
        .cur_x_i (cur_x_i),
        .cur_y_i (cur_y_i),
        .hit_o   (hit),
        .off_x_o (off_x),
        .off_y_o (off_y)
    );

    // Byte address: {pattern, line, plane, byte column}; a line is the
    // plane-0 bytes followed by the plane-1 bytes.
    always_comb begin
        enabled = (cur_sel_i == SEL_PAT0) || (cur_sel_i == SEL_PAT1);
        pat_bit = (cur_sel_i == SEL_PAT1);
        addr_p0 = {pat_bit, off_y, 1'b0, off_x[OFF_W-1 -: COL_W]};
        addr_p1 = {pat_bit, off_y, 1'b1, off_x[OFF_W-1 -: COL_W]};
        bit_sel = ~off_x[$clog2(BYTE_W)-1:0];
        mode    = cur_mode_e'({byte_p1[bit_sel], byte_p0[bit_sel]});
    end

    cursor_pat_store #(.BYTE_W(BYTE_W), .DEPTH(STORE_D)) i_store (
        .clk      (clk),
        .we_i     (pat_we_i),
        .waddr_i  (pat_waddr_i),
        .wdata_i  (pat_wdata_i),
        .raddr0_i (addr_p0),
        .raddr1_i (addr_p1),
        .rdata0_o (byte_p0),
        .rdata1_o (byte_p1)
    );

    cursor_mix #(.IDX_W(IDX_W)) i_mix (
        .active_i (enabled && hit),
        .mode_i   (mode),
        .idx_i    (pix_idx_i),
        .col0_i   (col0_i),
        .col1_i   (col1_i),
        .idx_o    (mixed_idx)
    );

    always_comb begin
        state_d.valid = pix_valid_i;
        state_d.idx   = pix_valid_i ? mixed_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid_o = state_q.valid;
    assign out_idx_o   = state_q.idx;
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int COORD_W = 11,
    parameter int IDX_W   = 8,
    parameter int CUR_DIM = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         cur_sel_i,
    input logic [COORD_W-1:0] cur_x_i,
    input logic [COORD_W-1:0] cur_y_i,
    input logic [IDX_W-1:0]   col0_i,
    input logic [IDX_W-1:0]   col1_i,
    input logic               pix_valid_i,
    input logic [IDX_W-1:0]   pix_idx_i,
    input logic [COORD_W-1:0] pix_x_i,
    input logic [COORD_W-1:0] pix_y_i,
    input logic               out_valid_o,
    input logic [IDX_W-1:0]   out_idx_o
);
    logic past_ok;
    logic in_box, cur_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        in_box = ({1'b0, pix_x_i} >= {1'b0, cur_x_i})
              && ({1'b0, pix_x_i} <= {1'b0, cur_x_i} + (COORD_W+1)'(CUR_DIM - 1))
              && ({1'b0, pix_y_i} >= {1'b0, cur_y_i})
              && ({1'b0, pix_y_i} <= {1'b0, cur_y_i} + (COORD_W+1)'(CUR_DIM - 1));
        cur_on = (cur_sel_i == 2'b01) || (cur_sel_i == 2'b10);
    end

    p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_valid_o == $past(pix_valid_i)));

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (out_idx_o == '0));

    p_off_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(pix_valid_i && !cur_on)) |-> (out_idx_o == $past(pix_idx_i)));

    p_outside_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(pix_valid_i && !in_box)) |-> (out_idx_o == $past(pix_idx_i)));

    // Covers R5, R6, R7 and R8: only the four legal results may appear.
    p_legal_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(pix_valid_i && in_box && cur_on)) |->
            (out_idx_o == $past(pix_idx_i) || out_idx_o == ~$past(pix_idx_i)
             || out_idx_o == $past(col0_i) || out_idx_o == $past(col1_i)));
endmodule

bind cursor_overlay cursor_overlay_chk #(
    .COORD_W(COORD_W), .IDX_W(IDX_W), .CUR_DIM(CUR_DIM)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cur_sel_i(cur_sel_i), .cur_x_i(cur_x_i),
    .cur_y_i(cur_y_i), .col0_i(col0_i), .col1_i(col1_i),
    .pix_valid_i(pix_valid_i), .pix_idx_i(pix_idx_i), .pix_x_i(pix_x_i),
    .pix_y_i(pix_y_i), .out_valid_o(out_valid_o), .out_idx_o(out_idx_o)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pat_we_i = 1'b0;
    logic [8:0]  pat_waddr_i = '0;
    logic [7:0]  pat_wdata_i = '0;
    logic [1:0]  cur_sel_i = '0;
    logic [10:0] cur_x_i = '0, cur_y_i = '0;
    logic [7:0]  col0_i = 8'h3C, col1_i = 8'hC3;
    logic        pix_valid_i = 1'b0;
    logic [7:0]  pix_idx_i = '0;
    logic [10:0] pix_x_i = '0, pix_y_i = '0;
    logic        out_valid_o;
    logic [7:0]  out_idx_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    cursor_overlay i_cursor_overlay (
        .clk(clk), .rst_n(rst_n), .pat_we_i(pat_we_i), .pat_waddr_i(pat_waddr_i),
        .pat_wdata_i(pat_wdata_i), .cur_sel_i(cur_sel_i), .cur_x_i(cur_x_i),
        .cur_y_i(cur_y_i), .col0_i(col0_i), .col1_i(col1_i),
        .pix_valid_i(pix_valid_i), .pix_idx_i(pix_idx_i), .pix_x_i(pix_x_i),
        .pix_y_i(pix_y_i), .out_valid_o(out_valid_o), .out_idx_o(out_idx_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] pat_byte(int p, int a);
        return 8'((a * 37 + p * 91 + 11) ^ (a >> 3));
    endfunction

    // Expected output and requirement tag, from R2..R8 and R10.
    function automatic logic [7:0] model(int sel, int cx, int cy, int px, int py,
                                         logic [7:0] idx, output string tag);
        int dx, dy, p, b;
        logic [7:0] b0, b1;
        logic [1:0] m;
        dx = px - cx;
        dy = py - cy;
        if (sel != 1 && sel != 2) begin tag = "R2"; return idx; end
        if (dx < 0 || dx > 31 || dy < 0 || dy > 31) begin tag = "R3"; return idx; end
        p  = sel - 1;
        b0 = pat_byte(p, dy * 8 + dx / 8);
        b1 = pat_byte(p, dy * 8 + 4 + dx / 8);
        b  = 7 - (dx % 8);
        m  = {b1[b], b0[b]};
        case (m)
            2'b00:   begin tag = "R5"; return col0_i; end
            2'b01:   begin tag = "R6"; return col1_i; end
            2'b10:   begin tag = "R7"; return idx;    end
            default: begin tag = "R8"; return ~idx;   end
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests = n_tests + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        pat_we_i = 1'b1; pat_waddr_i = 9'(a); pat_wdata_i = d;
        @(posedge clk);
        #1 pat_we_i = 1'b0;
    endtask

    task automatic pixel(int px, int py, logic v, string extra);
        logic [7:0] idx, e;
        string tag;
        idx = 8'(px ^ (py * 3));
        @(negedge clk);
        pix_valid_i = v; pix_x_i = 11'(px); pix_y_i = 11'(py); pix_idx_i = idx;
        e = model(int'(cur_sel_i), int'(cur_x_i), int'(cur_y_i), px, py, idx, tag);
        @(posedge clk);
        #1;
        if (!v) begin
            check("R1 valid", int'(out_valid_o), 0);
            check("R1 idle idx", int'(out_idx_o), 0);
        end else begin
            check({"R1 ", extra}, int'(out_valid_o), 1);
            check({tag, " R4 ", extra}, int'(out_idx_o), int'(e));
        end
    endtask

    task automatic place(int sel, int cx, int cy);
        @(negedge clk);
        cur_sel_i = 2'(sel); cur_x_i = 11'(cx); cur_y_i = 11'(cy);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 valid", int'(out_valid_o), 0);
        check("R9 idx", int'(out_idx_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int p = 0; p < 2; p++)
            for (int a = 0; a < 256; a++) wr(p * 256 + a, pat_byte(p, a));

        // Full box sweep for both patterns plus a margin.
        for (int s = 1; s <= 2; s++) begin
            place(s, 100, 50);
            for (int y = 48; y < 84; y++)
                for (int x = 97; x < 135; x++) pixel(x, y, 1'b1, "sweep");
        end

        // Cursor at the top line, with different colors.
        col0_i = 8'h5A; col1_i = 8'hA5;
        place(1, 0, 0);
        for (int y = 0; y < 34; y++)
            for (int x = 0; x < 34; x++) pixel(x, y, 1'b1, "origin");

        // Disabled codes pass everything.
        for (int s = 0; s < 4; s += 3) begin
            place(s, 10, 10);
            for (int y = 8; y < 20; y++)
                for (int x = 8; x < 20; x++) pixel(x, y, 1'b1, "off R2");
        end

        // Idle cycles.
        place(1, 10, 10);
        for (int i = 0; i < 4; i++) pixel(12 + i, 12, 1'b0, "idle");

        // Near the top of the coordinate range: no wrap.
        place(2, 2030, 2030);
        for (int y = 2026; y < 2048; y++)
            for (int x = 2024; x < 2048; x++) pixel(x, y, 1'b1, "R10 edge");
        for (int y = 0; y < 4; y++)
            for (int x = 0; x < 6; x++) pixel(x, y, 1'b1, "R10 low");
        for (int x = 0; x < 6; x++) pixel(x, 2040, 1'b1, "R10 xwrap");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule